// File: doc/BRIEF.md
# Five-Level Stacked-Carrier PWM Generator

This block drives a three-phase inverter in which every leg produces five voltage steps through a chain of four series switch pairs with flying capacitors. A phase accumulator steps through one sine period and produces three references spaced a third of a turn apart. Each reference is scaled by an amplitude word and quantised into one of five levels. The quantiser compares the reference against four triangular carriers. All four carriers come from one up/down counter, so they stay in phase, and each one is shifted into its own vertical band.

Each quantised level selects a fixed on/off pattern for the four pairs of its phase. Every pair turns its two complementary gates through a programmable blanking gap, so the outgoing and incoming switches never conduct together. The three phases yield 24 gate lines in total, and the signed level of each phase is also brought out. The carrier frequency is set by the counter peak value, and the reference frequency by the accumulator step. The ratio between the two is therefore the frequency modulation index.

Top module: `stacked_pwm5`

## Requirements
- R1: While `rst_n` is low, all 24 gate outputs are low and every level code reads 0. After release, the accumulator starts from 0 and the carrier counter starts from 0, counting upward.
- R2: One shared counter with peak P = `per_i` runs 0,1,…,P,P-1,…,1,0,1,… and changes by one step per clock. With P = 0 it stays at 0. For counter value c, the four carriers are c-2P, c-P, c and c+P.
- R3: The accumulator adds `freq_i` on every clock, modulo 2^ACC_W. For a phase angle h, bits [ACC_W-1:ACC_W-2] form the quadrant q and the next 8 bits form the index i. The index is mirrored to 255-i when q is odd. The magnitude is g = floor(i·(512-i)/32). The reference is m = floor(g·`amp_i`·P / 2^18), negated when q ≥ 2.
- R4: The three phases use the angles acc, acc+floor(2^ACC_W/3) and acc+floor(2·2^ACC_W/3), all taken modulo 2^ACC_W.
- R5: The level is (number of the two upper carriers c, c+P lying strictly below the reference) minus (number of the two lower carriers c-P, c-2P lying strictly above it). It ranges from -2 to +2. The level is registered: the code seen in cycle n+1 comes from the accumulator, counter and inputs of cycle n. `level_o[3p+2:3p]` holds the level of phase p as a 3-bit two's-complement value.
- R6: For each level, the wanted upper-switch states {S4,S3,S2,S1} are: +2 → 1111, +1 → 0111, 0 → 1100, -1 → 0001, -2 → 0000. Pair j of phase p (j = 0 for S1) drives its upper gate on `gate_o[8p+2j]` and its complementary lower gate on `gate_o[8p+2j+1]`.
- R7: The upper and lower gates of a pair are never high in the same cycle.
- R8: A pair whose wanted state differs from its applied state, while it is not blanking, takes the new state. It then holds both of its gates low for `dt_i` cycles before the incoming gate goes high. A wanted state that changes during blanking is handled only after the gap ends. With `dt_i` = 0, the switchover happens with no gap.
- R9: When `amp_i` is 0, every level code is 0 from the next cycle on, whatever the counter and accumulator hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_i | input | ACC_W | Accumulator step per clock (reference frequency) |
| per_i | input | CNT_W | Carrier counter peak P (band height) |
| amp_i | input | AMP_W | Amplitude index, full scale 2^AMP_W |
| dt_i | input | DT_W | Blanking gap in clock cycles |
| gate_o | output | 24 | Gate lines, two per switch pair, eight per phase |
| level_o | output | 9 | Signed 3-bit level per phase |

## Verification
The bench builds the block with its default widths: a 16-bit accumulator, a 10-bit counter, an 8-bit amplitude and a 4-bit gap. This lets it reach the largest blanking gap of 15 cycles and the full-scale amplitude of 255, where the reference enters the outer bands. Small carrier peaks (0, 1, 3, 5, 8, 20) are paired with a range of step words. As a result the counter's turning points, the degenerate flat carrier and many wraps of the accumulator all occur within a few thousand cycles. A behavioural model of the counter, the quarter-wave sine, the band rule and the per-pair blanking predicts every output on every clock. Runs with a zero gap and with a zero amplitude are also checked for the absence of blanking gaps and of non-zero levels.

// File: rtl/stacked_pwm5.sv
module stacked_pwm5 #(
  parameter int ACC_W = 16,
  parameter int CNT_W = 10,
  parameter int AMP_W = 8,
  parameter int DT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [AMP_W-1:0] amp_i,
  input  logic [DT_W-1:0]  dt_i,
  output logic [23:0]      gate_o,
  output logic [8:0]       level_o
);
  localparam int MAG_W = 11;
  localparam int SH    = MAG_W + AMP_W - 1;
  localparam int PW    = MAG_W + AMP_W + CNT_W;
  localparam int RW    = CNT_W + 3;

  logic [ACC_W-1:0] acc;
  logic [CNT_W-1:0] cnt;
  logic             up;
  logic signed [RW-1:0] cs, ps;

  assign cs = $signed(RW'(cnt));
  assign ps = $signed(RW'(per_i));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
      up  <= 1'b1;
    end else begin
      acc <= acc + freq_i;
      if (up) begin
        if (cnt < per_i) cnt <= cnt + CNT_W'(1);
        else begin
          up <= 1'b0;
          if (cnt != '0) cnt <= cnt - CNT_W'(1);
        end
      end else if (cnt != '0) cnt <= cnt - CNT_W'(1);
      else begin
        up <= 1'b1;
        if (per_i != '0) cnt <= CNT_W'(1);
      end
    end

  for (genvar p = 0; p < 3; p++) begin : g_ph
    localparam logic [ACC_W-1:0] OFF = ACC_W'((longint'(p) << ACC_W) / 3);
    logic [ACC_W-1:0]     ph;
    logic [7:0]           idx;
    logic [17:0]          pq;
    logic [MAG_W-1:0]     mag;
    logic [PW-1:0]        prod;
    logic [CNT_W:0]       mq;
    logic signed [RW-1:0] r;
    logic [2:0]           lv_n, lv;
    logic [3:0]           want;

    assign ph   = acc + OFF;
    assign idx  = ph[ACC_W-2] ? ~8'(ph >> (ACC_W-10)) : 8'(ph >> (ACC_W-10));
    assign pq   = {10'd0, idx} * (18'd512 - {10'd0, idx});
    assign mag  = MAG_W'(pq >> 5);
    assign prod = PW'(mag) * PW'(amp_i) * PW'(per_i);
    assign mq   = (CNT_W+1)'(prod >> SH);
    assign r    = ph[ACC_W-1] ? -$signed({2'b00, mq}) : $signed({2'b00, mq});
    assign lv_n = {2'b00, r > cs} + {2'b00, r > cs + ps}
                - {2'b00, r < cs - ps} - {2'b00, r < cs - ps - ps};

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lv <= '0;
      else        lv <= lv_n;

    assign level_o[3*p +: 3] = lv;

    always_comb
      case (lv)
        3'b010:  want = 4'b1111;
        3'b001:  want = 4'b0111;
        3'b000:  want = 4'b1100;
        3'b111:  want = 4'b0001;
        default: want = 4'b0000;
      endcase

    for (genvar j = 0; j < 4; j++) begin : g_pr
      logic            st;
      logic [DT_W-1:0] dc;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          st <= 1'b0;
          dc <= '0;
        end else if (dc != '0) dc <= dc - DT_W'(1);
        else if (want[j] != st) begin
          st <= want[j];
          dc <= dt_i;
        end

      assign gate_o[8*p+2*j]   = rst_n && dc == '0 && st;
      assign gate_o[8*p+2*j+1] = rst_n && dc == '0 && !st;
    end
  end
endmodule

// File: rtl/stacked_pwm5_chk.sv
module stacked_pwm5_chk #(
  parameter int AMP_W = 8,
  parameter int DT_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AMP_W-1:0] amp_i,
  input logic [DT_W-1:0]  dt_i,
  input logic [23:0]      gate_o,
  input logic [8:0]       level_o
);
  always @(posedge clk)
    if (!rst_n) AST_RESET_GATES_OFF: assert (gate_o == '0) else $error("gates on in reset"); // R1

  AST_ZERO_AMP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(amp_i) == '0 |-> level_o == '0); // R9

  for (genvar p = 0; p < 3; p++) begin : g_ph
    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      $signed(level_o[3*p +: 3]) >= -3'sd2 && $signed(level_o[3*p +: 3]) <= 3'sd2); // R5
    for (genvar j = 0; j < 4; j++) begin : g_pr
      AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_o[8*p+2*j] && gate_o[8*p+2*j+1])); // R7
      AST_GAP_AFTER_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_o[8*p+2*j]) && $past(dt_i) != '0 |-> !gate_o[8*p+2*j+1]); // R8
      AST_GAP_AFTER_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_o[8*p+2*j+1]) && $past(dt_i) != '0 |-> !gate_o[8*p+2*j]); // R8
    end
  end
endmodule

bind stacked_pwm5 stacked_pwm5_chk #(.AMP_W(AMP_W), .DT_W(DT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .amp_i(amp_i), .dt_i(dt_i),
  .gate_o(gate_o), .level_o(level_o)
);

// File: tb/stacked_pwm5_tb.sv
module stacked_pwm5_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] freq = '0;
  logic [9:0]  per = '0;
  logic [7:0]  amp = '0;
  logic [3:0]  dt = '0;
  logic [23:0] gate;
  logic [8:0]  level;

  int errors = 0, checks = 0, gapc = 0, nz = 0;
  bit done = 1'b0;
  bit seen_hi = 1'b0, seen_lo = 1'b0;
  int macc = 0, mcnt = 0, mup = 1;
  int mlv[3];
  int mst[12], mdc[12];

  always #2 clk = ~clk;

  stacked_pwm5 u_dut (
    .clk(clk), .rst_n(rst_n), .freq_i(freq), .per_i(per),
    .amp_i(amp), .dt_i(dt), .gate_o(gate), .level_o(level)
  );

  function automatic int pat(int lv);
    case (lv)
      2:       return 15;
      1:       return 7;
      0:       return 12;
      -1:      return 1;
      default: return 0;
    endcase
  endfunction

  // R3 reference and R5 band rule, computed from the stated formulas
  function automatic int lvl_of(int ph);
    int q = ph >> 14;
    int raw = (ph >> 6) & 255;
    int i = (q % 2 == 1) ? 255 - raw : raw;
    int g = (i * (512 - i)) >> 5;
    int pp = int'(per);
    longint m = (longint'(g) * longint'(int'(amp)) * longint'(pp)) >>> 18;
    int r = (q >= 2) ? -int'(m) : int'(m);
    int c = mcnt;
    return int'(r > c) + int'(r > c + pp) - int'(r < c - pp) - int'(r < c - 2*pp);
  endfunction

  task automatic model_step();
    int nl[3];
    if (!rst_n) begin
      macc = 0; mcnt = 0; mup = 1;
      for (int p = 0; p < 3; p++) mlv[p] = 0;
      for (int k = 0; k < 12; k++) begin mst[k] = 0; mdc[k] = 0; end
    end else begin
      for (int p = 0; p < 3; p++)
        for (int j = 0; j < 4; j++) begin
          int k = 4*p + j;
          int w = (pat(mlv[p]) >> j) & 1;
          if (mdc[k] != 0) mdc[k]--;
          else if (w != mst[k]) begin mst[k] = w; mdc[k] = int'(dt); end
        end
      // R4 phase offsets floor(p*2^16/3)
      for (int p = 0; p < 3; p++) nl[p] = lvl_of((macc + (p * 65536) / 3) & 65535);
      for (int p = 0; p < 3; p++) mlv[p] = nl[p];
      macc = (macc + int'(freq)) & 65535;
      // R2 triangle counter
      if (mup == 1) begin
        if (mcnt < int'(per)) mcnt++;
        else begin mup = 0; if (mcnt != 0) mcnt--; end
      end else if (mcnt != 0) mcnt--;
      else begin mup = 1; if (per != 0) mcnt = 1; end
    end
  endtask

  task automatic compare();
    logic [23:0] eg;
    for (int p = 0; p < 3; p++) begin
      int got = int'($signed(level[3*p +: 3]));
      checks++;
      if (got != mlv[p]) begin
        errors++;
        $display("FAIL R2 R3 R4 R5 level phase %0d: got %0d expected %0d", p, got, mlv[p]);
      end
      if (got != 0) nz++;
    end
    if (int'($signed(level[2:0])) == 2) seen_hi = 1'b1;
    if (int'($signed(level[2:0])) == -2) seen_lo = 1'b1;
    for (int k = 0; k < 12; k++) begin
      int p = k / 4, j = k % 4;
      eg[8*p+2*j]   = rst_n && mdc[k] == 0 && mst[k] == 1;
      eg[8*p+2*j+1] = rst_n && mdc[k] == 0 && mst[k] == 0;
      if (rst_n && !gate[8*p+2*j] && !gate[8*p+2*j+1]) gapc++;
    end
    checks++;
    if (gate !== eg) begin
      errors++;
      $display("FAIL R6/R8 gates: got %h expected %h", gate, eg);
    end
    checks++;
    if (((gate & 24'h555555) & ((gate >> 1) & 24'h555555)) != 0) begin
      errors++;
      $display("FAIL R7 pair overlap: got %h expected no pair with both on", gate);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic expect_true(bit ok, string what, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", what, got, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all requirements: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 3; p++) mlv[p] = 0;
    for (int k = 0; k < 12; k++) begin mst[k] = 0; mdc[k] = 0; end
    repeat (3) cyc();
    expect_true(gate == '0 && level == '0, "R1 reset outputs", int'(gate), 0);
    rst_n = 1'b1;

    per = 10'd8; amp = 8'd200; dt = 4'd2; freq = 16'd256;
    repeat (1000) cyc();
    expect_true(seen_hi && seen_lo, "R5 outer levels reached", int'(seen_hi) + int'(seen_lo), 2);

    per = 10'd5; amp = 8'd255; dt = 4'd0; freq = 16'd1000;
    repeat (30) cyc();
    gapc = 0;
    repeat (500) cyc();
    expect_true(gapc == 0, "R8 zero gap gives no blanking", gapc, 0);

    per = 10'd8; amp = 8'd0; dt = 4'd1;
    nz = 0;
    repeat (600) cyc();
    expect_true(nz == 0, "R9 zero amplitude levels", nz, 0);

    per = 10'd20; amp = 8'd128; dt = 4'd7; freq = 16'd97;
    gapc = 0;
    repeat (1500) cyc();
    expect_true(gapc > 0, "R8 blanking seen with nonzero gap", gapc, 1);

    per = 10'd3; amp = 8'd255; dt = 4'd15; freq = 16'd3000;
    repeat (1000) cyc();

    rst_n = 1'b0;
    repeat (2) cyc();
    expect_true(gate == '0 && level == '0, "R1 mid-run reset outputs", int'(gate), 0);
    rst_n = 1'b1;
    per = 10'd1; amp = 8'd255; dt = 4'd3; freq = 16'd40000;
    repeat (800) cyc();

    per = 10'd0;
    repeat (200) cyc();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule